// File: doc/BRIEF.md
# Dual-Mode Paged RAM Mapper

This block sits between a 16-bit CPU address bus and a 512 KB RAM array of 32 blocks of 16 KB each. The CPU address space is divided into four 16 KB windows, and each window has a six-bit page register. The CPU writes these registers through I/O writes whose address has bit 15 cleared. The page register that is written is chosen by I/O address bits 9:8. The write is taken only if data bits 7:6 are both set; any other data value belongs to a neighbouring control register file and leaves the mapper alone. Every register can also be read back through the same port addresses.

There are two ways to use the mapper, chosen by the `compat_mode` input. In paged mode, each window gets its physical block directly from its own register, and one write moves one window. In compatibility mode, a single write holds a three-bit configuration code and a three-bit 64 KB expansion bank. It is copied into all four registers, and all four windows are remapped together through a fixed eight-entry bank table. The physical address is formed combinationally from the current CPU address, so a new register value applies from the first cycle after the clock edge that captures it.

Top module: `paged_ram_mapper`

## Requirements
- R1: A register write happens only on a clock edge where `io_wr` is 1 and `cpu_addr[15]` is 0. Address bits 14:10 and 7:0 do not affect the decode.
- R2: `cpu_addr[9:8]` of the I/O write selects the page register: 0 is the window 0x0000-0x3FFF, 1 is 0x4000-0x7FFF, 2 is 0x8000-0xBFFF and 3 is 0xC000-0xFFFF.
- R3: A write whose `wr_data[7:6]` is not 2'b11 changes no register.
- R4: In paged mode (`compat_mode`=0), `phys_addr` = {reg[cpu_addr[15:14]][4:0], cpu_addr[13:0]}. Register bit 5 is stored but does not take part in translation.
- R5: In paged mode, an accepted write stores `wr_data[5:0]` in the addressed register only.
- R6: In compatibility mode (`compat_mode`=1), an accepted write to any of the four ports stores `wr_data[5:0]` in all four registers.
- R7: In compatibility mode, translation reads the page-0 register. Bits 2:0 are the configuration and bits 5:3 are the bank B. Window slots per configuration, listed as windows 0,1,2,3, are: 0:{0,1,2,3} 1:{0,1,2,X3} 2:{X0,X1,X2,X3} 3:{0,3,2,X3} 4:{0,X0,2,3} 5:{0,X1,2,3} 6:{0,X2,2,3} 7:{0,X3,2,3}. A plain slot n is block n. An expansion slot Xe is block (4*(B+1)+e) mod 32, so bank 7 wraps onto blocks 0-3. The low 14 bits pass through unchanged.
- R8: When `io_rd` is 1 and `cpu_addr[15]` is 0, `rd_valid` is 1 and `rd_data` is {2'b11, reg[cpu_addr[9:8]]}. Otherwise `rd_valid` and `rd_data` are 0.
- R9: After reset the registers hold 0, 1, 2 and 3 for windows 0 to 3. This gives an identity mapping onto blocks 0-3 in either mode.
- R10: Changing `compat_mode` alters no register. `phys_addr` follows the new mode in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address, used for both memory and I/O cycles |
| io_wr | input | 1 | I/O write strobe, sampled on the clock edge |
| io_rd | input | 1 | I/O read strobe |
| wr_data | input | 8 | CPU data for I/O writes |
| compat_mode | input | 1 | 1 selects compatibility mode, 0 selects paged mode |
| phys_addr | output | 19 | Physical RAM address |
| rd_data | output | 8 | Register read-back value |
| rd_valid | output | 1 | Read-back is driving `rd_data` |

## Verification
Some properties are checked on every cycle: registers hold their value unless a write was accepted, a paged write reaches at most one register and leaves the other three unchanged, a compatibility write leaves all four registers equal to the written value, and an I/O address with bit 15 set never produces a write or a read-back. Other behaviour can only be shown by the bench's scenarios. This covers the actual physical block chosen by each of the eight bank configurations, the bank wrap, the unused register bit 5, the choice among the four ports, and the way the mapping follows a mode change without a write.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int CPU_AW    = 16;
  localparam int OFFSET_W  = 14;
  localparam int PAGE_SEL_W = CPU_AW - OFFSET_W;
  localparam int PAGE_CNT  = 1 << PAGE_SEL_W;
  localparam int BLOCK_W   = 5;
  localparam int PHYS_AW   = BLOCK_W + OFFSET_W;
  localparam int REG_W     = 6;
  localparam int DATA_W    = 8;
  localparam int CFG_W     = 3;
  localparam int BANK_W    = REG_W - CFG_W;
  localparam int SLOT_W    = 3;

  typedef logic [REG_W-1:0]      page_reg_t;
  typedef logic [PAGE_SEL_W-1:0] page_sel_t;
  typedef logic [BLOCK_W-1:0]    block_t;
  typedef logic [SLOT_W-1:0]     slot_t;

  // Slot chosen for one window by a compatibility configuration.
  // Slot values 0..3 name main blocks, 4..7 name expansion blocks 0..3.
  function automatic slot_t compat_slot(input logic [CFG_W-1:0] cfg,
                                        input page_sel_t win);
    slot_t s;
    s = slot_t'(win);
    unique case (cfg)
      3'd0: s = slot_t'(win);
      3'd1: if (win == 2'd3) s = 3'd7;
      3'd2: s = slot_t'({1'b1, win});
      3'd3: begin
        if (win == 2'd1) s = 3'd3;
        if (win == 2'd3) s = 3'd7;
      end
      default: if (win == 2'd1) s = slot_t'(cfg);
    endcase
    return s;
  endfunction

  // Physical block for a slot inside a 64 KB expansion bank.
  function automatic block_t slot_to_block(input slot_t s,
                                           input logic [BANK_W-1:0] bank);
    logic [BLOCK_W:0] wide;
    if (!s[SLOT_W-1]) begin
      return block_t'(s[1:0]);
    end
    wide = ({1'b0, BLOCK_W'(bank)} + (BLOCK_W+1)'(1)) << 2;
    wide = wide + (BLOCK_W+1)'(s[1:0]);
    return wide[BLOCK_W-1:0];
  endfunction

  function automatic block_t compat_block(input page_reg_t cfg_reg,
                                          input page_sel_t win);
    return slot_to_block(compat_slot(cfg_reg[CFG_W-1:0], win),
                         cfg_reg[REG_W-1:CFG_W]);
  endfunction

  function automatic block_t paged_block(input page_reg_t r);
    return r[BLOCK_W-1:0];
  endfunction

endpackage

// File: rtl/mapper_port_decode.sv
module mapper_port_decode
  import mapper_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] wr_data,
  output logic          wr_accept,
  output page_sel_t     port_sel,
  output page_reg_t     wr_val,
  output logic          rd_hit
);

  localparam int TAG_W = DW - REG_W;

  logic port_hit;
  logic tag_ok;

  assign port_hit  = ~cpu_addr[AW-1];
  assign tag_ok    = &wr_data[DW-1 -: TAG_W];
  assign port_sel  = cpu_addr[9:8];
  assign wr_val    = wr_data[REG_W-1:0];
  assign wr_accept = io_wr & port_hit & tag_ok;
  assign rd_hit    = io_rd & port_hit;

  AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[AW-1] |-> (!wr_accept && !rd_hit)); // R1

endmodule

// File: rtl/mapper_page_regs.sv
module mapper_page_regs
  import mapper_pkg::*;
#(
  parameter int PAGES = PAGE_CNT
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_accept,
  input  page_sel_t port_sel,
  input  page_reg_t wr_val,
  input  logic      compat_mode,
  output page_reg_t page_q [PAGES]
);

  logic [PAGES-1:0] page_we;

  for (genvar i = 0; i < PAGES; i++) begin : g_page
    assign page_we[i] = wr_accept & (compat_mode | (port_sel == page_sel_t'(i)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        page_q[i] <= page_reg_t'(i);
      end else if (page_we[i]) begin
        page_q[i] <= wr_val;
      end
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_accept |=> $stable(page_q[i])); // R3

    AST_PAGED_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && !compat_mode && port_sel != page_sel_t'(i)) |=> $stable(page_q[i])); // R5

    AST_COMPAT_FILLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && compat_mode) |=> (page_q[i] == $past(wr_val))); // R6
  end

  AST_PAGED_SINGLE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !compat_mode |-> $onehot0(page_we)); // R5

endmodule

// File: rtl/mapper_translate.sv
module mapper_translate
  import mapper_pkg::*;
#(
  parameter int PAGES = PAGE_CNT
) (
  input  page_reg_t          page_q [PAGES],
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               compat_mode,
  output logic [PHYS_AW-1:0] phys_addr
);

  block_t    win_block [PAGES];
  page_sel_t win;
  block_t    sel_block;

  assign win = cpu_addr[CPU_AW-1:OFFSET_W];

  for (genvar i = 0; i < PAGES; i++) begin : g_win
    block_t paged_b;
    block_t compat_b;
    assign paged_b      = paged_block(page_q[i]);
    assign compat_b     = compat_block(page_q[0], page_sel_t'(i));
    assign win_block[i] = compat_mode ? compat_b : paged_b;
  end

  assign sel_block = win_block[win];
  assign phys_addr = {sel_block, cpu_addr[OFFSET_W-1:0]};

endmodule

// File: rtl/paged_ram_mapper.sv
module paged_ram_mapper
  import mapper_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               compat_mode,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid
);

  localparam int TAG_W = DATA_W - REG_W;

  logic      wr_accept;
  logic      rd_hit;
  page_sel_t port_sel;
  page_reg_t wr_val;
  page_reg_t page_q [PAGE_CNT];

  mapper_port_decode #(.AW(CPU_AW), .DW(DATA_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .wr_data   (wr_data),
    .wr_accept (wr_accept),
    .port_sel  (port_sel),
    .wr_val    (wr_val),
    .rd_hit    (rd_hit)
  );

  mapper_page_regs #(.PAGES(PAGE_CNT)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_accept   (wr_accept),
    .port_sel    (port_sel),
    .wr_val      (wr_val),
    .compat_mode (compat_mode),
    .page_q      (page_q)
  );

  mapper_translate #(.PAGES(PAGE_CNT)) u_xlate (
    .page_q      (page_q),
    .cpu_addr    (cpu_addr),
    .compat_mode (compat_mode),
    .phys_addr   (phys_addr)
  );

  assign rd_valid = rd_hit;
  assign rd_data  = rd_hit ? {{TAG_W{1'b1}}, page_q[port_sel]} : '0;

  AST_OFFSET_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFFSET_W-1:0] == cpu_addr[OFFSET_W-1:0]); // R4

  AST_MODE_SWITCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && compat_mode != $past(compat_mode)) |-> $stable(page_q[0])); // R10

endmodule

// File: tb/paged_ram_mapper_bench.sv
module paged_ram_mapper_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        compat_mode = 1'b0;
  logic [18:0] phys_addr;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [5:0] model [4];

  always #5 clk = ~clk;

  paged_ram_mapper u_paged_ram_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .io_wr(io_wr),
    .io_rd(io_rd), .wr_data(wr_data), .compat_mode(compat_mode),
    .phys_addr(phys_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected block, written from the requirement table.
  function automatic logic [4:0] exp_block(input int win, input logic cm);
    logic [2:0] cfg;
    logic [2:0] bank;
    int slot;
    if (!cm) return model[win][4:0];
    cfg  = model[0][2:0];
    bank = model[0][5:3];
    case (win)
      0: slot = (cfg == 2) ? 4 : 0;
      1: slot = (cfg == 2) ? 5 : (cfg == 3) ? 3 : (cfg >= 4) ? int'(cfg) : 1;
      2: slot = (cfg == 2) ? 6 : 2;
      default: slot = (cfg >= 1 && cfg <= 3) ? 7 : 3;
    endcase
    if (slot < 4) return 5'(slot);
    return 5'((int'(bank) * 4 + 4 + (slot - 4)) % 32);
  endfunction

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; wr_data = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (!a[15] && d[7:6] == 2'b11) begin
      if (compat_mode) for (int i = 0; i < 4; i++) model[i] = d[5:0];
      else model[a[9:8]] = d[5:0];
    end
  endtask

  task automatic check_window(input string req, input int win, input logic [13:0] off);
    cpu_addr = {2'(win), off};
    #1;
    chk(req, 32'(phys_addr), 32'({exp_block(win, compat_mode), off}));
  endtask

  task automatic check_readback(input string req, input int port);
    cpu_addr = 16'h7C00 | 16'(port << 8);
    io_rd = 1'b1;
    #1;
    chk(req, {23'd0, rd_valid, rd_data}, {23'd0, 1'b1, 2'b11, model[port]});
    io_rd = 1'b0;
  endtask

  task automatic check_all(input string req);
    for (int w = 0; w < 4; w++) begin
      check_window(req, w, 14'h1234 + 14'(w));
      check_readback(req, w);
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) model[i] = 6'(i);
    @(negedge clk);
    check_all("R9 paged");
    compat_mode = 1'b1;
    check_all("R9 compat");
    compat_mode = 1'b0;
  endtask

  task automatic t_paged;
    io_write(16'h7E00, 8'hC0 | 8'd17);
    check_all("R5 R2 page2");
    io_write(16'h0100, 8'hEA);          // bits 14:10 zero, bit5 set
    check_all("R4 R1 page1 bit5");
    io_write(16'h43FF, 8'hDF);          // port 3, odd low byte
    check_all("R2 page3");
    io_write(16'h7C00, 8'hC9);
    check_all("R5 page0");
  endtask

  task automatic t_reject;
    io_write(16'hFF00, 8'hFF);
    check_all("R1 a15 high");
    io_write(16'h7F00, 8'h85);
    check_all("R3 tag10");
    io_write(16'h7D00, 8'h7F);
    check_all("R3 tag01");
    @(negedge clk);
    cpu_addr = 16'h7E00; wr_data = 8'hFF; io_wr = 1'b0;
    @(negedge clk);
    check_all("R1 no strobe");
  endtask

  task automatic t_compat;
    compat_mode = 1'b1;
    for (int c = 0; c < 8; c++) begin
      io_write(16'h7C00 | 16'((c % 4) << 8), 8'hC0 | 8'((c * 3 % 8) << 3) | 8'(c));
      check_all("R6 R7 cfg");
    end
    io_write(16'h7D00, 8'hC0 | 8'(7 << 3) | 8'd2);   // bank 7 wraps
    check_all("R7 wrap");
    io_write(16'h7E00, 8'hC0 | 8'(5 << 3) | 8'd7);
    check_all("R7 cfg7");
  endtask

  task automatic t_mode_switch;
    compat_mode = 1'b0;
    #1;
    check_all("R10 to paged");
    compat_mode = 1'b1;
    #1;
    check_all("R10 to compat");
    compat_mode = 1'b0;
  endtask

  task automatic t_read_miss;
    cpu_addr = 16'hFD00; io_rd = 1'b1;
    #1;
    chk("R8 miss", {23'd0, rd_valid, rd_data}, 32'd0);
    io_rd = 1'b0; cpu_addr = 16'h7D00;
    #1;
    chk("R8 no strobe", {23'd0, rd_valid, rd_data}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_paged();
    t_reject();
    t_compat();
    t_mode_switch();
    t_read_miss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule